// File: doc/BRIEF.md
# Asymmetric Drift-Compensating Reference Tracker

This block holds a 16-bit reference level that follows a 16-bit raw sensor signal slowly and in single-count steps. The raw value arrives with a one-cycle strobe at the end of each acquisition burst. The reference moves only while the detect flag is low. Upward and downward movement each have their own rate setting. A setting of N means that one step is taken after N+1 consecutive qualifying bursts in the same direction. For example, a setting of 9 with bursts 100 ms apart gives one step per second.

Two thresholds are derived from the reference:
- The detect threshold is the reference plus a trip offset.
- The release threshold is the detect threshold minus a hysteresis offset.

Both are saturating sums, so they move with the reference and never wrap. A calibrate strobe copies the current raw sample into the reference at once and discards any partly counted interval. Deciding and confirming a detection is done outside this block.

Top module: `drift_ref_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, the reference becomes 0 and the interval progress is cleared.
- R2: With `cal_strobe` low, the reference changes only at an edge where `sample_valid` is high and `detect_active` is low. At every other edge it holds its value.
- R3: A burst arriving while `detect_active` is high leaves the reference unchanged and discards the interval progress counted so far.
- R4: Each step changes the reference by exactly one count toward `raw_sample`. The reference never passes the raw value.
- R5: When `raw_sample` is above the reference on `up_rate`+1 consecutive bursts, the reference rises by one after the edge of the last of those bursts.
- R6: When `raw_sample` is below the reference on `down_rate`+1 consecutive bursts, the reference falls by one after the edge of the last of those bursts.
- R7: A burst whose direction (above or below the reference) differs from the previous burst restarts the interval count, and that burst counts as the first of the new interval.
- R8: A burst with `raw_sample` equal to the reference restarts the interval count and takes no step.
- R9: When `cal_strobe` is high at an edge, the reference is loaded with `raw_sample` and the interval progress is cleared. This takes priority over `detect_active`, `sample_valid` and reset-free stepping.
- R10: `trip_level` equals reference plus `trip_offset`, saturated at 65535.
- R11: `release_level` equals `trip_level` minus `hyst_offset`, saturated at 0.
- R12: With a rate setting of 0, every qualifying burst in that direction takes a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-cycle strobe: a new raw sample is present |
| raw_sample | input | 16 | Raw signal value |
| detect_active | input | 1 | High while a detection is in effect; freezes tracking |
| up_rate | input | 8 | Upward interval setting, interval = setting+1 bursts |
| down_rate | input | 8 | Downward interval setting, interval = setting+1 bursts |
| trip_offset | input | 16 | Offset from reference to detect threshold |
| hyst_offset | input | 16 | Offset from detect threshold down to release threshold |
| cal_strobe | input | 1 | Load reference from raw sample and clear interval progress |
| ref_level | output | 16 | Tracked reference level |
| trip_level | output | 16 | Detect threshold |
| release_level | output | 16 | Release threshold |

## Verification
The progress inside a partial interval cannot be seen at the ports. Its clearing by a direction change, an equal sample or a frozen burst can only be shown by timing the next step. Each such scenario first recalibrates to a known reference. It then feeds fewer bursts than the interval in one direction, applies the disturbing burst, and counts the bursts until the next step. The step must arrive after a full interval and not after the remainder, and the reference is checked at every burst along the way.

// File: rtl/drift_pkg.sv
package drift_pkg;

    localparam int SAMPLE_W = 16;
    localparam int RATE_W   = 8;

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DOWN = 2'b10
    } drift_dir_e;

    typedef struct packed {
        drift_dir_e dir;
        logic       due;
    } step_req_t;

endpackage

// File: rtl/drift_dir_classifier.sv
module drift_dir_classifier
    import drift_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic [W-1:0] raw_value,
    input  logic [W-1:0] ref_value,
    output drift_dir_e   dir
);
    always_comb begin
        if (raw_value > ref_value)      dir = DIR_UP;
        else if (raw_value < ref_value) dir = DIR_DOWN;
        else                            dir = DIR_NONE;
    end
endmodule

// File: rtl/drift_interval_timer.sv
module drift_interval_timer
    import drift_pkg::*;
#(
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic          flush,
    input  drift_dir_e    dir,
    input  logic [RW-1:0] up_rate,
    input  logic [RW-1:0] down_rate,
    output step_req_t     req
);
    localparam int CW = RW + 1;

    logic [CW-1:0] cnt_q;
    drift_dir_e    last_q;
    logic [CW-1:0] limit;
    logic [CW-1:0] base;
    logic [CW-1:0] nxt;
    logic          due;

    // interval length: selected rate plus one
    always_comb begin
        if (dir == DIR_DOWN) limit = {1'b0, down_rate} + CW'(1);
        else                 limit = {1'b0, up_rate} + CW'(1);
        base = (dir == last_q) ? cnt_q : '0;
        nxt  = base + CW'(1);
        due  = advance && (dir != DIR_NONE) && (nxt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt_q  <= '0;
            last_q <= DIR_NONE;
        end else if (advance) begin
            if (dir == DIR_NONE) begin
                cnt_q  <= '0;
                last_q <= DIR_NONE;
            end else if (due) begin
                cnt_q  <= '0;
                last_q <= dir;
            end else begin
                cnt_q  <= nxt;
                last_q <= dir;
            end
        end
    end

    assign req.dir = dir;
    assign req.due = due;
endmodule

// File: rtl/drift_thresh_gen.sv
module drift_thresh_gen #(
    parameter int W = 16
) (
    input  logic [W-1:0] ref_value,
    input  logic [W-1:0] trip_off,
    input  logic [W-1:0] hyst_off,
    output logic [W-1:0] trip_value,
    output logic [W-1:0] release_value
);
    logic [W:0] sum_wide;
    logic [W:0] diff_wide;

    always_comb begin
        sum_wide = {1'b0, ref_value} + {1'b0, trip_off};
        trip_value = sum_wide[W] ? {W{1'b1}} : sum_wide[W-1:0];
        diff_wide = {1'b0, trip_value} - {1'b0, hyst_off};
        release_value = diff_wide[W] ? '0 : diff_wide[W-1:0];
    end
endmodule

// File: rtl/drift_ref_tracker.sv
module drift_ref_tracker
    import drift_pkg::*;
#(
    parameter int W  = SAMPLE_W,
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_valid,
    input  logic [W-1:0]  raw_sample,
    input  logic          detect_active,
    input  logic [RW-1:0] up_rate,
    input  logic [RW-1:0] down_rate,
    input  logic [W-1:0]  trip_offset,
    input  logic [W-1:0]  hyst_offset,
    input  logic          cal_strobe,
    output logic [W-1:0]  ref_level,
    output logic [W-1:0]  trip_level,
    output logic [W-1:0]  release_level
);
    logic [W-1:0] ref_q;
    drift_dir_e   dir;
    step_req_t    req;
    logic         track_en;
    logic         flush;

    assign track_en = sample_valid && !detect_active && !cal_strobe;
    assign flush    = cal_strobe || (sample_valid && detect_active);

    drift_dir_classifier #(.W(W)) cls_i (
        .raw_value (raw_sample),
        .ref_value (ref_q),
        .dir       (dir)
    );

    drift_interval_timer #(.RW(RW)) tmr_i (
        .clk       (clk),
        .rst       (rst),
        .advance   (track_en),
        .flush     (flush),
        .dir       (dir),
        .up_rate   (up_rate),
        .down_rate (down_rate),
        .req       (req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
        end else if (cal_strobe) begin
            ref_q <= raw_sample;
        end else if (req.due) begin
            if (req.dir == DIR_UP)        ref_q <= ref_q + W'(1);
            else if (req.dir == DIR_DOWN) ref_q <= ref_q - W'(1);
        end
    end

    drift_thresh_gen #(.W(W)) thr_i (
        .ref_value     (ref_q),
        .trip_off      (trip_offset),
        .hyst_off      (hyst_offset),
        .trip_value    (trip_level),
        .release_value (release_level)
    );

    assign ref_level = ref_q;
endmodule

// File: rtl/drift_ref_tracker_chk.sv
module drift_ref_tracker_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         sample_valid,
    input logic [W-1:0] raw_sample,
    input logic         detect_active,
    input logic         cal_strobe,
    input logic [W-1:0] ref_level,
    input logic [W-1:0] trip_level,
    input logic [W-1:0] release_level
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ref_level == '0));

    assert_hold_no_burst_R2: assert property (@(posedge clk) disable iff (rst)
        (!cal_strobe && !sample_valid) |=> $stable(ref_level));

    assert_frozen_detect_R3: assert property (@(posedge clk) disable iff (rst)
        (!cal_strobe && detect_active) |=> $stable(ref_level));

    assert_unit_step_R4: assert property (@(posedge clk) disable iff (rst)
        !cal_strobe |=> (ref_level == $past(ref_level) ||
                         ref_level == $past(ref_level) + W'(1) ||
                         ref_level == $past(ref_level) - W'(1)));

    assert_no_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (!cal_strobe && raw_sample <= ref_level) |=> (ref_level <= $past(ref_level)));

    assert_no_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (!cal_strobe && raw_sample >= ref_level) |=> (ref_level >= $past(ref_level)));

    assert_cal_load_R9: assert property (@(posedge clk) disable iff (rst)
        cal_strobe |=> (ref_level == $past(raw_sample)));

    assert_trip_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        trip_level >= ref_level);

    assert_release_no_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        release_level <= trip_level);
endmodule

bind drift_ref_tracker drift_ref_tracker_chk #(.W(W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .sample_valid  (sample_valid),
    .raw_sample    (raw_sample),
    .detect_active (detect_active),
    .cal_strobe    (cal_strobe),
    .ref_level     (ref_level),
    .trip_level    (trip_level),
    .release_level (release_level)
);

// File: tb/drift_ref_tracker_tb_top.sv
module drift_ref_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        sample_valid;
    logic [15:0] raw_sample;
    logic        detect_active;
    logic [7:0]  up_rate;
    logic [7:0]  down_rate;
    logic [15:0] trip_offset;
    logic [15:0] hyst_offset;
    logic        cal_strobe;
    logic [15:0] ref_level;
    logic [15:0] trip_level;
    logic [15:0] release_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    drift_ref_tracker dut_i (
        .clk           (clk),
        .rst           (rst),
        .sample_valid  (sample_valid),
        .raw_sample    (raw_sample),
        .detect_active (detect_active),
        .up_rate       (up_rate),
        .down_rate     (down_rate),
        .trip_offset   (trip_offset),
        .hyst_offset   (hyst_offset),
        .cal_strobe    (cal_strobe),
        .ref_level     (ref_level),
        .trip_level    (trip_level),
        .release_level (release_level)
    );

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one burst: inputs set at negedge, result sampled at following negedge
    task automatic burst(input logic [15:0] raw, input logic det);
        sample_valid  = 1'b1;
        raw_sample    = raw;
        detect_active = det;
        @(negedge clk);
        sample_valid  = 1'b0;
        detect_active = 1'b0;
    endtask

    task automatic calibrate(input logic [15:0] raw);
        cal_strobe = 1'b1;
        raw_sample = raw;
        @(negedge clk);
        cal_strobe = 1'b0;
    endtask

    task automatic t_reset();
        trip_offset = 16'd100;
        hyst_offset = 16'd30;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check16("R1 ref after reset", ref_level, 16'd0);
        check16("R10 trip after reset", trip_level, 16'd100);
        check16("R11 release after reset", release_level, 16'd70);
    endtask

    task automatic t_cal();
        sample_valid = 1'b1;
        detect_active = 1'b1;
        calibrate(16'd500);
        sample_valid = 1'b0;
        detect_active = 1'b0;
        check16("R9 cal over detect and burst", ref_level, 16'd500);
        calibrate(16'd1000);
        check16("R9 cal load", ref_level, 16'd1000);
        check16("R10 trip follows ref", trip_level, 16'd1100);
        check16("R11 release follows ref", release_level, 16'd1070);
    endtask

    task automatic t_up();
        up_rate = 8'd3;
        calibrate(16'd1000);
        for (int i = 0; i < 3; i++) begin
            burst(16'd1010, 1'b0);
            check16("R5 no step before interval", ref_level, 16'd1000);
        end
        burst(16'd1010, 1'b0);
        check16("R5 step after up_rate+1 bursts", ref_level, 16'd1001);
        repeat (4) burst(16'd1010, 1'b0);
        check16("R5 second upward step", ref_level, 16'd1002);
        check16("R10 trip moved with ref", trip_level, 16'd1102);
    endtask

    task automatic t_down();
        down_rate = 8'd1;
        calibrate(16'd1000);
        burst(16'd990, 1'b0);
        check16("R6 no step before interval", ref_level, 16'd1000);
        burst(16'd990, 1'b0);
        check16("R6 step after down_rate+1 bursts", ref_level, 16'd999);
    endtask

    task automatic t_no_strobe();
        calibrate(16'd1000);
        raw_sample = 16'd1200;
        repeat (20) @(negedge clk);
        check16("R2 no change without burst", ref_level, 16'd1000);
    endtask

    task automatic t_dir_change();
        up_rate = 8'd3;
        down_rate = 8'd3;
        calibrate(16'd1000);
        repeat (3) burst(16'd1010, 1'b0);
        burst(16'd990, 1'b0);
        check16("R7 reversal does not step", ref_level, 16'd1000);
        repeat (2) burst(16'd990, 1'b0);
        check16("R7 count restarted at reversal", ref_level, 16'd1000);
        burst(16'd990, 1'b0);
        check16("R7 step after full new interval", ref_level, 16'd999);
    endtask

    task automatic t_equal();
        up_rate = 8'd3;
        calibrate(16'd1000);
        repeat (3) burst(16'd1010, 1'b0);
        burst(16'd1000, 1'b0);
        check16("R8 equal sample no step", ref_level, 16'd1000);
        repeat (3) burst(16'd1010, 1'b0);
        check16("R8 count restarted by equal", ref_level, 16'd1000);
        burst(16'd1010, 1'b0);
        check16("R8 step after full interval", ref_level, 16'd1001);
    endtask

    task automatic t_detect();
        up_rate = 8'd3;
        calibrate(16'd1000);
        repeat (2) burst(16'd1010, 1'b0);
        repeat (2) burst(16'd1010, 1'b1);
        check16("R3 frozen during detect", ref_level, 16'd1000);
        repeat (3) burst(16'd1010, 1'b0);
        check16("R3 progress discarded by detect", ref_level, 16'd1000);
        burst(16'd1010, 1'b0);
        check16("R3 step after full interval", ref_level, 16'd1001);
    endtask

    task automatic t_rate0();
        up_rate = 8'd0;
        calibrate(16'd1000);
        burst(16'd1002, 1'b0);
        check16("R12 step every burst 1", ref_level, 16'd1001);
        burst(16'd1002, 1'b0);
        check16("R12 step every burst 2", ref_level, 16'd1002);
        repeat (3) burst(16'd1002, 1'b0);
        check16("R4 stops at raw", ref_level, 16'd1002);
    endtask

    task automatic t_sat();
        trip_offset = 16'd100;
        hyst_offset = 16'd200;
        calibrate(16'd65500);
        check16("R10 trip saturates high", trip_level, 16'd65535);
        check16("R11 release from saturated trip", release_level, 16'd65335);
        trip_offset = 16'd5;
        hyst_offset = 16'd50;
        calibrate(16'd10);
        @(negedge clk);
        check16("R10 trip small", trip_level, 16'd15);
        check16("R11 release saturates low", release_level, 16'd0);
        trip_offset = 16'd100;
        hyst_offset = 16'd30;
    endtask

    initial begin
        rst = 1'b1;
        sample_valid = 1'b0;
        raw_sample = '0;
        detect_active = 1'b0;
        up_rate = 8'd3;
        down_rate = 8'd3;
        trip_offset = '0;
        hyst_offset = '0;
        cal_strobe = 1'b0;
        @(negedge clk);
        t_reset();
        t_cal();
        t_up();
        t_down();
        t_no_strobe();
        t_dir_change();
        t_equal();
        t_detect();
        t_rate0();
        t_sat();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule